// File: doc/BRIEF.md
# Packet Byte-to-Word Packer

The packer sits between a character-level receive path and a 36-bit-wide receive FIFO. Each incoming character is either a data byte or an end marker. An end marker is a normal end or an error end. The packer gathers characters into words of four byte lanes, and each lane has one flag bit. The first character of a word lands in the most significant lane, and later characters fill lower lanes. A marker is written into the lane it arrives in and sets that lane's flag. It also closes the word at once, so the consumer can work out the exact frame length from the position of the flagged lane.

Characters enter on a valid/ready handshake. A character is taken on a rising edge where `in_valid` and `in_ready` are both high. Back-pressure comes only from the FIFO. The packer holds one completed word. While that word is waiting and `fifo_full` is high, `in_ready` is low. When the FIFO has room, the waiting word is pushed and a new character is taken in the same cycle. No character is lost or repeated.

On the output side, `fifo_push` is a one-cycle write strobe. `fifo_word` is valid whenever `fifo_push` is high. A word is pushed no earlier than the cycle after the character that completed it was taken.

Top module: `byte_word_packer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fifo_push` is 0 and `in_ready` is 1.
- R2: The first character of a word is placed in bits 31:24. The second goes to bits 23:16, the third to 15:8 and the fourth to 7:0.
- R3: Four consecutive data bytes form one word with flag bits 35:32 all zero. That word appears on `fifo_push` in the cycle after the fourth byte is taken, unless `fifo_full` is high.
- R4: A marker taken after k data bytes of the current word (k = 0..3) goes into lane k. Lane 0 is bits 31:24 and lane 3 is bits 7:0. The marker sets flag bit 35-k. The marker lane holds 8'h01 for an error end and 8'h00 for a normal end, so bits 7:1 are zero.
- R5: A marker completes its word immediately. Every lane below the marker lane is zero.
- R6: A pushed word has at most one flag bit set.
- R7: While a completed word waits and `fifo_full` is high, `fifo_push` stays low, `in_ready` stays low and the held word does not change. Every accepted character appears in exactly one pushed word, in order.
- R8: `in_err` has no effect when `in_mark` is 0. The data byte is stored unchanged.
- R9: A synchronous reset in the middle of a word discards the partial word. The next character goes to bits 31:24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Character present on the input |
| in_ready | output | 1 | Packer can take a character this cycle |
| in_data | input | 8 | Data byte (used when `in_mark` is 0) |
| in_mark | input | 1 | Character is an end marker |
| in_err | input | 1 | Marker kind: 1 = error end, 0 = normal end |
| fifo_full | input | 1 | Receive FIFO has no space |
| fifo_push | output | 1 | Write strobe into the FIFO |
| fifo_word | output | 36 | Word to write: flags in 35:32, lanes in 31:0 |

## Verification
The bench sweeps every marker position from lane 0 to lane 3. It places each one after zero to nine leading data bytes and uses both marker kinds, so a packer that counts lanes in the wrong direction, puts the flag on the wrong bit, or leaves stale bytes below the marker shows a miscompare. It then repeats the whole sweep with `fifo_full` toggling pseudo-randomly. In that run, a packer that drops or duplicates a character when a word collides with a full FIFO either breaks the word order or leaves words missing at the end. Data bytes carry `in_err` set to catch a design that lets that bit leak into a byte. A reset in the middle of a word, followed by a lone marker, shows whether the partial lanes and the lane counter are really cleared.

// File: rtl/byte_pack_pkg.sv
package byte_pack_pkg;

  localparam int CHAR_BITS = 8;

  typedef enum logic {
    END_NORMAL = 1'b0,
    END_ERROR  = 1'b1
  } end_kind_e;

  // Encoded lane contents for an end marker: only the low bit carries the kind.
  function automatic logic [CHAR_BITS-1:0] end_code(input end_kind_e kind);
    end_code = {{(CHAR_BITS-1){1'b0}}, kind == END_ERROR};
  endfunction

endpackage

// File: rtl/bwp_lane_fill.sv
module bwp_lane_fill
  import byte_pack_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int DATA_W = LANES * CHAR_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [CHAR_BITS-1:0] ch_data,
  input  logic                 ch_mark,
  input  logic                 ch_err,
  output logic                 done,
  output logic [DATA_W-1:0]    done_lanes,
  output logic [LANES-1:0]     done_flags
);

  logic [IDX_W-1:0] idx_q;
  logic             last_lane;
  logic [CHAR_BITS-1:0] mark_byte;

  assign last_lane = (idx_q == IDX_W'(LANES - 1));
  assign done      = take & (ch_mark | last_lane);
  assign mark_byte = end_code(ch_err ? END_ERROR : END_NORMAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (done) begin
      idx_q <= '0;
    end else if (take) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CHAR_BITS-1:0] lane_q;
    logic [CHAR_BITS-1:0] lane_out;
    logic                 hit;

    assign hit = take && (idx_q == IDX_W'(i));

    always_comb begin
      if (hit) begin
        lane_out = ch_mark ? mark_byte : ch_data;
      end else if (IDX_W'(i) < idx_q) begin
        lane_out = lane_q;
      end else begin
        lane_out = '0;
      end
    end

    assign done_lanes[(LANES-i)*CHAR_BITS-1 -: CHAR_BITS] = lane_out;
    assign done_flags[LANES-1-i] = hit & ch_mark;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (hit && !done) begin
        lane_q <= ch_data;
      end
    end
  end

  // After a word closes, filling restarts at the top lane (R2, R9).
  assert_restart_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idx_q == '0));

endmodule

// File: rtl/bwp_word_hold.sv
module bwp_word_hold #(
  parameter int WORD_W = 36,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              full,
  output logic              pending,
  output logic              push,
  output logic [WORD_W-1:0] word
);

  assign push = pending & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      word    <= '0;
    end else if (load) begin
      pending <= 1'b1;
      word    <= load_word;
    end else if (push) begin
      pending <= 1'b0;
    end
  end

  // A blocked word is kept intact until the FIFO takes it (R7).
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && full) |=> (pending && $stable(word)));

  // Never more than one terminated lane per word (R6).
  assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $onehot0(word[WORD_W-1 -: FLAG_W]));

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import byte_pack_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DATA_W = LANES * CHAR_BITS,
  localparam int WORD_W = DATA_W + LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CHAR_BITS-1:0] in_data,
  input  logic                 in_mark,
  input  logic                 in_err,
  input  logic                 fifo_full,
  output logic                 fifo_push,
  output logic [WORD_W-1:0]    fifo_word
);

  logic              take;
  logic              word_done;
  logic [DATA_W-1:0] lanes;
  logic [LANES-1:0]  flags;
  logic              pending;

  assign in_ready = ~(pending & fifo_full);
  assign take     = in_valid & in_ready;

  bwp_lane_fill #(.LANES(LANES)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .ch_data    (in_data),
    .ch_mark    (in_mark),
    .ch_err     (in_err),
    .done       (word_done),
    .done_lanes (lanes),
    .done_flags (flags)
  );

  bwp_word_hold #(.WORD_W(WORD_W), .FLAG_W(LANES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (word_done),
    .load_word ({flags, lanes}),
    .full      (fifo_full),
    .pending   (pending),
    .push      (fifo_push),
    .word      (fifo_word)
  );

  // A taken character that closes a word is pushed next cycle unless blocked (R3).
  assert_push_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (fifo_push || fifo_full));

  for (genvar f = 0; f < LANES; f++) begin : g_mark_chk
    // Marker lane carries only the kind bit (R4).
    assert_marker_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && fifo_word[DATA_W+f]) |->
        (fifo_word[f*CHAR_BITS+CHAR_BITS-1 : f*CHAR_BITS+1] == '0));
    for (genvar g = 0; g < f; g++) begin : g_tail
      // Lanes after the marker are zero-filled (R5).
      assert_zero_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_word[DATA_W+f]) |->
          (fifo_word[g*CHAR_BITS +: CHAR_BITS] == '0));
    end
  end

endmodule

// File: tb/test_byte_word_packer.sv
`timescale 1ns/100ps
module test_byte_word_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_mark = 1'b0;
  logic        in_err = 1'b0;
  logic        fifo_full = 1'b0;
  logic        fifo_push;
  logic [35:0] fifo_word;

  int n_checks = 0;
  int n_fails = 0;
  bit full_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [35:0] exp_q[$];
  string       tag_q[$];
  int          m_cnt = 0;
  logic [35:0] m_word = '0;
  bit          done_flag = 0;

  always #2.5 clk = ~clk;

  byte_word_packer i_byte_word_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .in_err(in_err),
    .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_word(fifo_word)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  task automatic update_full();
    if (full_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fifo_full = lfsr[0] & lfsr[3];
    end else begin
      fifo_full = 1'b0;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    update_full();
  endtask

  // Reference model: lane k at bits 31-8k, flag at 35-k.
  task automatic model(input logic [7:0] d, input bit mark, input bit err, input string tag);
    if (!mark) begin
      m_word[31-8*m_cnt -: 8] = d;
      m_cnt++;
    end else begin
      m_word[31-8*m_cnt -: 8] = {7'b0, err};
      m_word[35-m_cnt] = 1'b1;
      m_cnt = 4;
    end
    if (m_cnt == 4) begin
      exp_q.push_back(m_word);
      tag_q.push_back(tag);
      m_word = '0;
      m_cnt = 0;
    end
  endtask

  task automatic send(input logic [7:0] d, input bit mark, input bit err, input string tag);
    bit ok;
    in_valid = 1'b1;
    in_data  = d;
    in_mark  = mark;
    in_err   = err;
    do begin
      #1 ok = in_ready;
      @(negedge clk);
      update_full();
    end while (!ok);
    in_valid = 1'b0;
    model(d, mark, err, tag);
  endtask

  task automatic drain();
    full_mode = 0;
    for (int w = 0; w < 50 && exp_q.size() != 0; w++) tick();
    check(exp_q.size() == 0, "R7 drain", 36'(exp_q.size()), 36'd0);
  endtask

  // Output monitor, sampled after the falling edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && fifo_full) check(!fifo_push, "R7 push while full", 36'(fifo_push), 36'd0);
    if (rst_n && fifo_push) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected push", fifo_word, 36'd0);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(fifo_word === e, t, fifo_word, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      check(1'b0, "watchdog", 36'd0, 36'd1);
      report();
    end
  end

  initial begin
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      #1 check(!fifo_push && in_ready, "R1 in reset", {34'd0, fifo_push, in_ready}, 36'd1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(!fifo_push && in_ready, "R1 after release", {34'd0, fifo_push, in_ready}, 36'd1);
    @(negedge clk);

    // Sweep: leading data bytes, marker kinds, with and without back-pressure.
    for (int fm = 0; fm < 2; fm++) begin
      full_mode = bit'(fm);
      for (int n = 0; n < 10; n++) begin
        for (int e = 0; e < 2; e++) begin
          for (int k = 0; k < n; k++) begin
            // in_err set on odd data bytes must not matter (R8)
            send(8'((n * 16 + k * 7 + e * 3 + fm * 128) ^ 8'h5A), 1'b0, k[0], "R2/R3/R8 data word");
          end
          send(8'hFF, 1'b1, bit'(e), "R4/R5/R6 marker word");
        end
      end
      drain();
    end

    // R9: reset in the middle of a word discards the partial bytes.
    send(8'hA1, 1'b0, 1'b0, "R9 discarded");
    send(8'hB2, 1'b0, 1'b0, "R9 discarded");
    @(negedge clk);
    rst_n = 1'b0;
    m_cnt = 0;
    m_word = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h00, 1'b1, 1'b1, "R9 marker at top lane");
    drain();
    check(m_cnt == 0, "R9 model idle", 36'(m_cnt), 36'd0);

    done_flag = 1;
    report();
  end

endmodule